// File: doc/BRIEF.md
# Asynchronous SRAM strobe controller

This block sits between a clocked host and an external 32K x 8 asynchronous static RAM. That RAM has no output-enable pin. It is selected only while an active-low enable and an active-high enable are both asserted. While selected, its write strobe sets the direction: strobe high means the RAM drives data, and strobe low means the RAM samples data. The controller turns each host request into a timed sequence of select, strobe and bus-drive signals. Every phase length is a whole number of clock cycles. Each length is the ceiling of a nanosecond limit divided by the clock period, and is never less than one cycle. The nanosecond limits are parameters, so that one build can target either speed grade. The defaults assume a 10 ns clock and the 35 ns grade.

The host side is a valid/ready request channel followed by a one-cycle response pulse. A request transfers on a cycle where both `req_valid` and `req_ready` are high. While `req_ready` is low, the host must hold the request steady. The response channel applies no back-pressure: `rsp_valid` is high for exactly one cycle per request, and the host must accept it in that cycle. The memory-side data bus comes out as three pins: an output value, an output enable and an input value. The pad ring joins them into one bidirectional bus.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mem_ce_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: A request transfers when `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the cycle after the response pulse. Each transferred request produces exactly one response, and a request held during that time is not taken twice.
- R3: The RAM is selected (`mem_ce_n`=0 together with `mem_ce2`=1) only during a read or write phase. At all other times both enables are inactive, and they are always inactive whenever `req_ready` is high.
- R4: A read holds the RAM selected with `mem_we_n`=1 for exactly RD_CYC cycles (default 4, from 35 ns). `mem_addr` shows the request address from the first of these cycles and stays stable through all of them.
- R5: Read data is sampled from `mem_dq_in` at the clock edge that ends the last read cycle. `rsp_valid` is then high for the next single cycle, which comes RD_CYC edges after the transfer edge, and `rsp_rdata` carries the sampled byte.
- R6: A write holds `mem_we_n`=0 for exactly WR_CYC cycles (default 4), with the RAM selected. WR_CYC is the largest of the write cycle, pulse width, address-to-end and float-plus-data-setup limits. `mem_we_n` is never low while the RAM is deselected.
- R7: `mem_dq_oe` rises only after the RAM has floated its outputs, which takes WHZ_CYC cycles of strobe low (default 2, from 15 ns). It stays high through the end of the strobe and for one hold cycle after it, during which the RAM is deselected. Throughout, `mem_dq_out` carries the request's write byte.
- R8: `mem_dq_oe` is low during every read cycle and during the cycle before it, so the two sides never drive the bus at the same time.
- R9: For a write, `rsp_valid` is high for one cycle, WR_CYC+1 edges after the transfer edge.
- R10: A write leaves `rsp_rdata` unchanged. It keeps the byte from the most recent read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte from the latest read |
| mem_addr | output | 15 | RAM address bus |
| mem_dq_out | output | 8 | Value driven onto the RAM data bus |
| mem_dq_oe | output | 1 | Drive enable for the RAM data bus |
| mem_dq_in | input | 8 | Value seen on the RAM data bus |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_ce2 | output | 1 | RAM select, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |

## Verification
The response to a read is due four clock edges after the transfer edge, and the response to a write is due five edges after it. When the driver sees a request transfer, it records the due cycle number in the scoreboard entry. The monitor then checks that the response pulse arrives in exactly that cycle. A behavioural RAM model measures the strobe and select phases in whole cycles, each one sampled on the falling clock edge. It compares the read and write phase lengths and the cycle on which the bus drive begins against their fixed expected counts. Data integrity is checked end to end: bytes written through the controller are read back later through the controller.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_HOLD,
    ST_DONE
  } seq_state_e;

  // cycles needed to cover a nanosecond limit, never fewer than one
  function automatic int cycles_for(input int limit_ns, input int period_ns);
    int c;
    c = (limit_ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == CNT_W'(1));

  AST_CNT_PARKS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !load) |=> (cnt == '0)); // R4

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int RD_CYC    = 4,
  parameter int WR_CYC    = 4,
  parameter int DRV_LIMIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CNT_W-1:0] cnt,
  input  logic             last,
  output logic             req_ready,
  output logic             accept,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             sel,
  output logic             we_low,
  output logic             drive,
  output logic             capture,
  output logic             done
);

  seq_state_e state, state_nx;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign load      = accept;
  assign load_val  = req_write ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (accept) state_nx = req_write ? ST_WRITE : ST_READ;
      ST_READ:  if (last)   state_nx = ST_DONE;
      ST_WRITE: if (last)   state_nx = ST_HOLD;
      ST_HOLD:              state_nx = ST_DONE;
      ST_DONE:              state_nx = ST_IDLE;
      default:              state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  // bus is driven once the RAM has had time to float, and one cycle after
  assign sel     = (state == ST_READ) || (state == ST_WRITE);
  assign we_low  = (state == ST_WRITE);
  assign drive   = ((state == ST_WRITE) && (cnt <= CNT_W'(DRV_LIMIT))) ||
                   (state == ST_HOLD);
  assign capture = (state == ST_READ) && last;
  assign done    = (state == ST_DONE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready); // R2

endmodule

// File: rtl/sram_bus_stage.sv
module sram_bus_stage #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic              sel,
  input  logic              we_low,
  input  logic              drive,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  // address is registered on the same edge that opens the phase
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_in;
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = drive;
  assign mem_ce_n   = !sel;
  assign mem_ce2    = sel;
  assign mem_we_n   = !we_low;
  assign rsp_rdata  = rdata_q;

  AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_ce2)); // R6

  AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n || $past(!mem_we_n))); // R7

  AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && mem_we_n) |-> (!mem_dq_oe && !$past(mem_dq_oe))); // R8

  AST_WRITE_KEEPS_RDATA: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> $stable(rsp_rdata)); // R10

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_RC_NS   = 35,
  parameter int T_WC_NS   = 35,
  parameter int T_WP_NS   = 25,
  parameter int T_AW_NS   = 30,
  parameter int T_DW_NS   = 20,
  parameter int T_WHZ_NS  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_we_n
);

  localparam int RD_CYC    = cycles_for(T_RC_NS, CLK_NS);
  localparam int WHZ_CYC   = cycles_for(T_WHZ_NS, CLK_NS);
  localparam int DW_CYC    = cycles_for(T_DW_NS, CLK_NS);
  localparam int WR_CYC    = imax(imax(cycles_for(T_WC_NS, CLK_NS),
                                       cycles_for(T_WP_NS, CLK_NS)),
                                  imax(cycles_for(T_AW_NS, CLK_NS),
                                       WHZ_CYC + DW_CYC));
  localparam int DRV_LIMIT = WR_CYC - WHZ_CYC;
  localparam int CNT_W     = $clog2(imax(RD_CYC, WR_CYC) + 1);

  logic             accept, load, last;
  logic [CNT_W-1:0] load_val, cnt;
  logic             sel, we_low, drive, capture, done;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .cnt      (cnt),
    .last     (last)
  );

  sram_seq_fsm #(
    .CNT_W     (CNT_W),
    .RD_CYC    (RD_CYC),
    .WR_CYC    (WR_CYC),
    .DRV_LIMIT (DRV_LIMIT)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .cnt       (cnt),
    .last      (last),
    .req_ready (req_ready),
    .accept    (accept),
    .load      (load),
    .load_val  (load_val),
    .sel       (sel),
    .we_low    (we_low),
    .drive     (drive),
    .capture   (capture),
    .done      (done)
  );

  sram_bus_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture    (capture),
    .sel        (sel),
    .we_low     (we_low),
    .drive      (drive),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_ce_n   (mem_ce_n),
    .mem_ce2    (mem_ce2),
    .mem_we_n   (mem_we_n),
    .rsp_rdata  (rsp_rdata)
  );

  assign rsp_valid = done;

  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && !mem_ce2)); // R3

  AST_RSP_NEEDS_PHASE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!req_ready)); // R2

endmodule

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int RD_EXP  = 4;
  localparam int WR_EXP  = 4;
  localparam int WHZ_EXP = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_in;
  logic        mem_ce_n, mem_ce2, mem_we_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_strobe_ctrl i_sram_strobe_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
    .mem_we_n(mem_we_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] blank_byte(input logic [14:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  // ---------------- behavioural RAM model ----------------
  logic [7:0] ram [int];
  logic [7:0] shadow [int];

  always_comb begin
    if (!mem_ce_n && mem_ce2 && mem_we_n)
      mem_dq_in = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : blank_byte(mem_addr);
    else
      mem_dq_in = 'z;
  end

  int          we_cnt = 0, rd_cnt = 0;
  logic        p_we_n = 1'b1, p_oe = 1'b0;
  logic [14:0] rd_addr, wr_addr;
  logic [7:0]  wr_data;

  always @(negedge clk) begin
    if (!rst) begin
      automatic logic sel = !mem_ce_n && mem_ce2;
      if (mem_ce_n != !mem_ce2) chk(1'b0, "R3 enables split", mem_ce2, !mem_ce_n);
      if (req_ready) chk(!sel, "R3 idle select", sel, 0);
      // read phase
      if (sel && mem_we_n) begin
        chk(!mem_dq_oe && !p_oe, "R8 bus free", {p_oe, mem_dq_oe}, 0);
        if (rd_cnt == 0) rd_addr = mem_addr;
        else if (mem_addr != rd_addr) chk(1'b0, "R4 addr stable", mem_addr, rd_addr);
        rd_cnt++;
      end else if (rd_cnt != 0) begin
        chk(rd_cnt == RD_EXP, "R4 read length", rd_cnt, RD_EXP);
        rd_cnt = 0;
      end
      // write phase
      if (!mem_we_n) begin
        if (!sel) chk(1'b0, "R6 strobe unselected", sel, 1);
        we_cnt++;
        if (mem_dq_oe) begin
          if (we_cnt <= WHZ_EXP) chk(1'b0, "R7 early drive", we_cnt, WHZ_EXP + 1);
          wr_data = mem_dq_out;
        end
        wr_addr = mem_addr;
      end else if (we_cnt != 0) begin
        chk(we_cnt == WR_EXP, "R6 strobe length", we_cnt, WR_EXP);
        chk(mem_dq_oe && !sel, "R7 hold cycle", {mem_dq_oe, sel}, 2'b10);
        chk(p_oe, "R7 drive at strobe end", p_oe, 1);
        ram[int'(wr_addr)] = wr_data;
        we_cnt = 0;
      end
      if (mem_dq_oe && mem_we_n && p_we_n) chk(1'b0, "R7 stray drive", mem_dq_oe, 0);
      p_we_n = mem_we_n;
      p_oe   = mem_dq_oe;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit wr; logic [7:0] data; int due; } exp_t;
  exp_t sb_q [$];
  logic [7:0] last_rd = 8'h00;

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R2 extra response", 1, 0);
      end else begin
        automatic exp_t e = sb_q.pop_front();
        if (e.wr) begin
          chk(cyc == e.due, "R9 write latency", cyc, e.due);
          chk(rsp_rdata == last_rd, "R10 rdata kept", rsp_rdata, last_rd);
        end else begin
          chk(cyc == e.due, "R5 read latency", cyc, e.due);
          chk(rsp_rdata == e.data, "R5 read data", rsp_rdata, e.data);
          last_rd = e.data;
        end
      end
    end
  end

  task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
    exp_t e;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    e.wr  = wr;
    e.due = cyc + 1 + (wr ? WR_EXP + 1 : RD_EXP);
    if (wr) begin
      shadow[int'(a)] = d;
      e.data = d;
    end else begin
      e.data = shadow.exists(int'(a)) ? shadow[int'(a)] : blank_byte(a);
    end
    sb_q.push_back(e);
    @(negedge clk);
    chk(!req_ready, "R2 ready drops", req_ready, 0);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && !mem_ce2 && mem_we_n && !mem_dq_oe && !rsp_valid && req_ready,
        "R1 reset outputs", {mem_ce_n, mem_ce2, mem_we_n, mem_dq_oe, rsp_valid, req_ready},
        6'b101001);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && !mem_ce2 && req_ready, "R1 after reset", {mem_ce_n, mem_ce2, req_ready}, 3'b101);

    do_op(1'b1, 15'h0000, 8'h3C);
    do_op(1'b1, 15'h7FFF, 8'hC3);
    do_op(1'b1, 15'h1234, 8'h5A);
    do_op(1'b0, 15'h0000, 8'h00);
    do_op(1'b1, 15'h5555, 8'hFF);   // write right after read: R10
    do_op(1'b0, 15'h7FFF, 8'h00);   // read right after write: R8
    do_op(1'b0, 15'h1234, 8'h00);
    do_op(1'b0, 15'h0ABC, 8'h00);   // never written
    do_op(1'b0, 15'h5555, 8'h00);
    do_op(1'b1, 15'h1234, 8'h00);   // overwrite
    do_op(1'b0, 15'h1234, 8'h00);
    do_op(1'b1, 15'h2AAA, 8'h81);
    do_op(1'b1, 15'h2AAB, 8'h7E);
    do_op(1'b0, 15'h2AAB, 8'h00);
    do_op(1'b0, 15'h2AAA, 8'h00);

    repeat (12) @(negedge clk);
    chk(sb_q.size() == 0, "R2 responses complete", sb_q.size(), 0);
    chk(req_ready && mem_ce_n && !mem_ce2, "R3 final idle", {req_ready, mem_ce_n, mem_ce2}, 3'b110);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule